// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block turns bytes written by a processor into a serial bit stream. The processor writes a character into a holding register and a line format into a format register. When the shift engine is idle, it takes the waiting character from the holding register. Because of this, software can queue the next byte while the current one is still going out, and consecutive characters leave with no idle time between them.

The line format can be asynchronous or clocked synchronous. Asynchronous frames have a start bit, 7 or 8 data bits, an optional parity bit or multiprocessor bit, and one or two stop bits. Synchronous mode always sends 8 data bits with no framing bits. In that mode the block also drives a shift clock, and data changes on the falling edge of that clock. Data always leaves LSB first.

The time for one bit is `BIT_DIV` system clocks multiplied by a prescale of 1, 4, 16 or 64, picked by a two-bit field.

Top module: `sertx_top`

## Requirements
- R1: After synchronous reset, the holding register reads 0xFF and the format register reads 0x00. The empty flag, the transmit-end flag, `txd` and `sck` are all 1.
- R2: A write with `wr_sel`=0 loads the holding register and a write with `wr_sel`=1 loads the format register. `rd_data` returns the register chosen by `rd_sel` (0 holding, 1 format) one cycle after the select is applied.
- R3: A holding write clears `hold_empty` in the next cycle. When the shifter is idle or finishing its last bit, it takes a full holding register and `hold_empty` returns to 1.
- R4: If the next byte is written before the current frame ends, its first bit follows the last bit of the current frame with no idle bit between them.
- R5: Asynchronous mode is format bit 7 = 0. A frame is a low start bit, then data LSB first, then high stop bits. Format bit 3 selects one stop bit (0) or two (1).
- R6: In asynchronous mode, format bit 6 = 1 selects 7 data bits, and holding bit 7 is not sent.
- R7: Format bit 5 enables a parity bit after the data bits. Format bit 4 selects even parity (0) or odd parity (1). No parity bit is sent in synchronous mode or when format bit 2 is set.
- R8: When format bit 2 is set in asynchronous mode, the value of `mp_bit` at load time is sent in the slot after the data bits.
- R9: Synchronous mode is format bit 7 = 1. It sends exactly 8 data bits LSB first with no start or stop bits, whatever format bit 6 holds. `sck` is low for the first half of each bit and high for the second half, and it idles high.
- R10: Each bit lasts `BIT_DIV` × {1, 4, 16, 64} system clocks, selected by format bits 1:0 = 0, 1, 2, 3.
- R11: `tx_end` is 1 exactly when the shifter is idle and the holding register is empty, and the line is then high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 holding, 1 format |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | Read source: 0 holding, 1 format |
| rd_data | output | 8 | Registered read data |
| mp_bit | input | 1 | Multiprocessor bit value sampled at frame load |
| txd | output | 1 | Serial data line |
| sck | output | 1 | Shift clock in synchronous mode, high otherwise |
| hold_empty | output | 1 | Holding register may be written |
| tx_end | output | 1 | Shifter idle and holding register empty |

## Verification
The embedded assertions check, on every cycle, how the empty flag reacts to writes and loads, that the line holds steady inside a bit, that the shifter's bit counter stays within frame length, and that the line is high whenever transmission has ended. Frame content, parity polarity, 7-bit truncation, multiprocessor insertion, gapless streaming and exact bit duration can only be shown by the bench scenarios. These scenarios sample the line at bit centres or on shift-clock rising edges and compare the result against a stream the bench builds from the format rules.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  typedef struct packed {
    logic       sync;
    logic       chr7;
    logic       par_en;
    logic       par_odd;
    logic       stop2;
    logic       mp_en;
    logic [1:0] cks;
  } fmt_t;

  localparam int FRAME_MAX = 12;
  localparam int LEN_W = 4;
endpackage

// File: rtl/sertx_rate.sv
module sertx_rate #(
  parameter int BIT_DIV = 4,
  parameter int PW = 9
) (
  input  logic [1:0]    cks,
  output logic [PW-1:0] period
);
  logic [PW-1:0] opt [4];

  for (genvar g = 0; g < 4; g++) begin : g_opt
    assign opt[g] = PW'(BIT_DIV << (2 * g));
  end

  assign period = opt[cks];
endmodule

// File: rtl/sertx_frame.sv
module sertx_frame
  import sertx_pkg::*;
(
  input  fmt_t                 fmt,
  input  logic [7:0]           data,
  input  logic                 mp_bit,
  output logic [FRAME_MAX-1:0] bits,
  output logic [LEN_W-1:0]     len
);
  logic [LEN_W-1:0] pos;
  logic [LEN_W-1:0] nd;
  logic             par;

  always_comb begin
    bits = '1;
    pos  = '0;
    nd   = (fmt.sync || !fmt.chr7) ? 4'd8 : 4'd7;
    par  = fmt.par_odd;
    if (!fmt.sync) begin
      bits[pos] = 1'b0;
      pos = pos + 1'b1;
    end
    for (int i = 0; i < 8; i++) begin
      if (4'(i) < nd) begin
        bits[pos] = data[i];
        par = par ^ data[i];
        pos = pos + 1'b1;
      end
    end
    if (!fmt.sync && (fmt.mp_en || fmt.par_en)) begin
      bits[pos] = fmt.mp_en ? mp_bit : par;
      pos = pos + 1'b1;
    end
    if (!fmt.sync) pos = pos + (fmt.stop2 ? 4'd2 : 4'd1);
    len = pos;
  end
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
  import sertx_pkg::*;
#(
  parameter int PW = 9
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sync_mode,
  input  logic                 hold_full,
  input  logic [FRAME_MAX-1:0] bits,
  input  logic [LEN_W-1:0]     len,
  input  logic [PW-1:0]        period,
  output logic                 load,
  output logic                 txd,
  output logic                 sck,
  output logic                 busy
);
  logic                 busy_q, sync_q, txd_q;
  logic [FRAME_MAX-1:0] sh_q;
  logic [LEN_W-1:0]     left_q;
  logic [PW-1:0]        tmr_q;
  logic                 bit_done;

  assign bit_done = busy_q && (tmr_q == '0);
  assign load     = hold_full && (!busy_q || (bit_done && left_q == '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      sync_q <= 1'b0;
      txd_q  <= 1'b1;
      sh_q   <= '1;
      left_q <= '0;
      tmr_q  <= '0;
    end else if (load) begin
      busy_q <= 1'b1;
      sync_q <= sync_mode;
      txd_q  <= bits[0];
      sh_q   <= {1'b1, bits[FRAME_MAX-1:1]};
      left_q <= len - 1'b1;
      tmr_q  <= period - 1'b1;
    end else if (bit_done) begin
      if (left_q != '0) begin
        txd_q  <= sh_q[0];
        sh_q   <= {1'b1, sh_q[FRAME_MAX-1:1]};
        left_q <= left_q - 1'b1;
        tmr_q  <= period - 1'b1;
      end else begin
        busy_q <= 1'b0;
        txd_q  <= 1'b1;
      end
    end else if (busy_q) begin
      tmr_q <= tmr_q - 1'b1;
    end
  end

  assign txd  = txd_q;
  assign busy = busy_q;
  assign sck  = !(busy_q && sync_q && (tmr_q >= (period >> 1)));

  a_r10_bit_stable: assert property (@(posedge clk) disable iff (rst)
    (busy_q && tmr_q != '0) |=> $stable(txd_q));
  a_r5_count_bound: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (left_q < LEN_W'(FRAME_MAX)));
endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int BIT_DIV = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  input  logic       rd_sel,
  output logic [7:0] rd_data,
  input  logic       mp_bit,
  output logic       txd,
  output logic       sck,
  output logic       hold_empty,
  output logic       tx_end
);
  localparam int PW = $clog2(BIT_DIV * 64 + 1);

  logic [7:0]           hold_q;
  fmt_t                 fmt_q;
  logic                 empty_q;
  logic [7:0]           rd_q;
  logic [PW-1:0]        period;
  logic [FRAME_MAX-1:0] fbits;
  logic [LEN_W-1:0]     flen;
  logic                 ld, busy, wr_hold;

  assign wr_hold = wr_en && !wr_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= 8'hFF;
      fmt_q   <= '0;
      empty_q <= 1'b1;
      rd_q    <= 8'hFF;
    end else begin
      if (wr_en && wr_sel) fmt_q <= fmt_t'(wr_data);
      if (wr_hold) begin
        hold_q  <= wr_data;
        empty_q <= 1'b0;
      end else if (ld) begin
        empty_q <= 1'b1;
      end
      rd_q <= rd_sel ? 8'(fmt_q) : hold_q;
    end
  end

  sertx_rate #(.BIT_DIV(BIT_DIV), .PW(PW)) i_rate (
    .cks(fmt_q.cks), .period(period));

  sertx_frame i_frame (
    .fmt(fmt_q), .data(hold_q), .mp_bit(mp_bit), .bits(fbits), .len(flen));

  sertx_shift #(.PW(PW)) i_shift (
    .clk(clk), .rst(rst), .sync_mode(fmt_q.sync), .hold_full(!empty_q),
    .bits(fbits), .len(flen), .period(period),
    .load(ld), .txd(txd), .sck(sck), .busy(busy));

  assign rd_data    = rd_q;
  assign hold_empty = empty_q;
  assign tx_end     = !busy && empty_q;

  a_r3_write_clears: assert property (@(posedge clk) disable iff (rst)
    wr_hold |=> !hold_empty);
  a_r3_load_sets: assert property (@(posedge clk) disable iff (rst)
    (ld && !wr_hold) |=> hold_empty);
  a_r11_line_high_at_end: assert property (@(posedge clk) disable iff (rst)
    tx_end |-> txd);
  a_r9_sck_idle_high: assert property (@(posedge clk) disable iff (rst)
    tx_end |-> sck);
endmodule

// File: tb/test_sertx_top.sv
module test_sertx_top;
  localparam int BIT_DIV = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0, mp_bit = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       txd, sck, hold_empty, tx_end;

  int n_cmp = 0;
  int n_bad = 0;
  bit expq[$];

  always #10 clk = ~clk;

  sertx_top #(.BIT_DIV(BIT_DIV)) i_sertx_top (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .mp_bit(mp_bit), .txd(txd), .sck(sck),
    .hold_empty(hold_empty), .tx_end(tx_end));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int bit_period(input logic [7:0] f);
    return BIT_DIV << (2 * f[1:0]);
  endfunction

  task automatic add_frame(input logic [7:0] f, input logic [7:0] d, input logic mp);
    int nd;
    bit p;
    nd = (f[7] || !f[6]) ? 8 : 7;
    p = f[4];
    if (!f[7]) expq.push_back(1'b0);
    for (int i = 0; i < nd; i++) begin
      expq.push_back(d[i]);
      p ^= d[i];
    end
    if (!f[7]) begin
      if (f[2]) expq.push_back(mp);
      else if (f[5]) expq.push_back(p);
      expq.push_back(1'b1);
      if (f[3]) expq.push_back(1'b1);
    end
  endtask

  task automatic reg_write(input logic sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic sel, output logic [7:0] v);
    @(negedge clk);
    rd_sel = sel;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic run(input logic [7:0] f, input int nb, input logic [7:0] d0,
                     input logic [7:0] d1, input logic [7:0] d2, input logic mp);
    logic [7:0] data [3];
    logic [7:0] v;
    int per, total;
    data[0] = d0; data[1] = d1; data[2] = d2;
    per = bit_period(f);
    mp_bit = mp;
    reg_write(1'b1, f);
    reg_read(1'b1, v);
    check(v == f, "R2 format readback", v, f);
    expq.delete();
    for (int i = 0; i < nb; i++) add_frame(f, data[i], mp);
    total = expq.size();
    fork
      begin
        for (int i = 0; i < nb; i++) begin
          while (!hold_empty) @(negedge clk);
          @(negedge clk);
          wr_en = 1'b1; wr_sel = 1'b0; wr_data = data[i];
          @(negedge clk);
          wr_en = 1'b0;
          if (i == 0) check(hold_empty == 1'b0, "R3 empty cleared by write", hold_empty, 0);
        end
      end
      begin
        if (!f[7]) begin
          while (txd) @(negedge clk);
          repeat (per / 2) @(negedge clk);
          for (int k = 0; k < total; k++) begin
            check(txd == expq[k], "R4/R5/R6/R7/R8/R10 async bit", txd, expq[k]);
            repeat (per) @(negedge clk);
          end
        end else begin
          for (int k = 0; k < total; k++) begin
            logic p;
            p = sck;
            forever begin
              @(negedge clk);
              if (sck && !p) break;
              p = sck;
            end
            check(txd == expq[k], "R9 sync bit on sck rise", txd, expq[k]);
          end
        end
      end
    join
    for (int t = 0; t < 4000 && !tx_end; t++) @(negedge clk);
    check(tx_end == 1'b1 && txd == 1'b1 && sck == 1'b1, "R11 end state", {tx_end, txd, sck}, 3'b111);
    check(hold_empty == 1'b1, "R3 empty after load", hold_empty, 1);
    reg_read(1'b0, v);
    check(v == data[nb-1], "R2 holding readback", v, data[nb-1]);
  endtask

  task automatic start_len(input logic [1:0] cks);
    int n;
    reg_write(1'b1, {6'b000000, cks});
    reg_write(1'b0, 8'h01);
    while (txd) @(negedge clk);
    n = 0;
    while (!txd) begin
      n++;
      @(negedge clk);
    end
    check(n == (BIT_DIV << (2 * cks)), "R10 start bit length", n, BIT_DIV << (2 * cks));
    while (!tx_end) @(negedge clk);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(hold_empty == 1'b1 && tx_end == 1'b1, "R1 flags after reset", {hold_empty, tx_end}, 2'b11);
    check(txd == 1'b1 && sck == 1'b1, "R1 lines after reset", {txd, sck}, 2'b11);
    reg_read(1'b0, v);
    check(v == 8'hFF, "R1 holding reset", v, 8'hFF);
    reg_read(1'b1, v);
    check(v == 8'h00, "R1 format reset", v, 8'h00);

    run(8'h00, 3, 8'hA5, 8'h3C, 8'h81, 1'b0);   // R4 R5 gapless 8N1
    run(8'h68, 2, 8'hFF, 8'h80, 8'h00, 1'b0);   // R6 R7 7-bit even, 2 stop
    run(8'h30, 2, 8'h01, 8'h07, 8'h00, 1'b0);   // R7 odd parity
    run(8'h24, 2, 8'h55, 8'hAA, 8'h00, 1'b1);   // R8 mp replaces parity
    run(8'h24, 1, 8'h0F, 8'h00, 8'h00, 1'b0);   // R8 mp bit low
    run(8'hE1, 3, 8'hC3, 8'h12, 8'hFE, 1'b1);   // R9 sync ignores chr7/parity
    run(8'h03, 1, 8'h96, 8'h00, 8'h00, 1'b0);   // R10 slowest prescale
    for (int c = 0; c < 4; c++) start_len(2'(c));
    for (int r = 0; r < 8; r++) begin
      logic [7:0] f;
      f = 8'($urandom);
      f[1:0] = 2'($urandom % 3);
      run(f, 2 + ($urandom % 2), 8'($urandom), 8'($urandom), 8'($urandom), 1'($urandom));
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule